// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave port through which a host reads and writes a bank of eight-bit configuration registers. Every transfer opens with an instruction that carries the direction, a byte count of one to four and a start address. A data phase follows, in which consecutive registers are accessed while the port steps the address on its own. The registers are also presented in parallel on a flat output bus, so neighbouring logic sees every write as soon as the byte has arrived.

The port runs on the chip's system clock and treats the serial clock as a sampled input. A serial-clock rising edge is recognised in the system-clock cycle in which the sampled level changes from low to high. Register 0 holds three control bits: bit order, instruction length and the choice between a shared data pin and a dedicated output pin. The port takes a copy of these bits while it is idle, so a change made during a transfer applies from the next one. The host may pause a transfer at a byte boundary by raising chip select. Raising it in the middle of a byte abandons the transfer. A pin-mode input shuts the whole port off.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset every register reads 0, `sdio_oe` is 0 and `sdo` is 0.
- R2: In the short format the first 8 received bits form the instruction: bit 7 is the direction (1 = read, 0 = write), bits 6:5 are the count code (00, 01, 10 and 11 give 1, 2, 3 and 4 data bytes), and bits 4:0 are the start address. With most-significant-bit-first order, instruction and data bytes arrive bit 7 first and the address decreases by one after each byte, modulo 8192.
- R3: A write byte lands in its register in the system-clock cycle after the cycle in which its 8th rising edge is recognised, before the transfer ends. Register i appears on `regs_o[8i+7:8i]`.
- R4: In a read, the first bit of the first data byte is driven after the last instruction edge. Each rising edge after that moves the output to the next bit, and the next register is loaded after the 8th edge of a byte. Nothing is driven while `cs_n` is high.
- R5: When register 0 bit 6 is 1, instruction and data bytes travel bit 0 first, and the address increases by one after each byte.
- R6: When register 0 bit 4 is 1, the instruction is 16 bits long. The first byte holds the direction, the count code and address bits 12:8 in the R2 positions. The second byte holds address bits 7:0. Addresses 0 to 31 are implemented; reads elsewhere return 0 and writes elsewhere change nothing.
- R7: When register 0 bit 3 is 1, read data leaves on `sdo` and `sdio_oe` stays 0. When the bit is 0, read data leaves on `sdio_o` with `sdio_oe` at 1, and `sdo` stays 0.
- R8: A change to the register 0 control bits takes effect from the next transfer only. Bytes later in the same transfer still use the old settings.
- R9: Raising `cs_n` after a complete byte that is not the last one holds the transfer. It continues when `cs_n` falls again.
- R10: Raising `cs_n` after a partial byte ends the transfer without writing that byte, and the next instruction is decoded from scratch.
- R11: While `pin_mode` is 1 the port ignores the serial clock, changes no register, drives neither output and returns to waiting for an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pin_mode | input | 1 | High disables the serial port |
| sclk | input | 1 | Serial clock, sampled on `clk` |
| cs_n | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data in |
| sdio_o | output | 1 | Read data on the shared pin |
| sdio_oe | output | 1 | Drive enable for the shared pin |
| sdo | output | 1 | Read data on the dedicated output pin |
| regs_o | output | NUM_REGS*8 | Parallel view of all registers |

## Verification
The hardest case to reach is a write to register 0 that changes the control bits in the middle of a multibyte transfer, followed by more bytes in the same transfer. A correct port must finish that transfer with the old bit order and address direction. The stimulus does this directly: in bit-0-first order it starts at address 0, clears the order bit in the first byte and sends a lopsided pattern in the second byte, which would land mirrored if the new setting took hold early. Random transfers with a fixed seed then mix both orders, both instruction lengths, both pin choices, stalls and unimplemented addresses.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int BYTE_W    = 8;
    localparam int WIDE_AW   = 13;
    localparam int CNT_W     = 3;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    bit_cnt;
        logic                hi_done;
        logic                rw;
        logic [1:0]          left;
        logic [WIDE_AW-1:0]  addr;
        logic [BYTE_W-1:0]   rx;
        logic [BYTE_W-1:0]   tx;
        logic                reading;
        logic                cfg_lsb;
        logic                cfg_long;
        logic                cfg_4w;
    } ctrl_state_t;

endpackage

// File: rtl/spi_sclk_edge.sv
module spi_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = sclk & ~prev_q;
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
    import spi_cfg_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WIDE_AW-1:0]         wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [WIDE_AW-1:0]         rd_addr,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam logic [WIDE_AW-1:0] LIMIT = WIDE_AW'(NUM_REGS);

    logic [BYTE_W-1:0] regs_d [NUM_REGS];
    logic [BYTE_W-1:0] regs_q [NUM_REGS];
    logic              wr_hit, rd_hit;
    logic [IDX_W-1:0]  wr_idx, rd_idx;

    assign wr_hit = wr_addr < LIMIT;
    assign rd_hit = rd_addr < LIMIT;
    assign wr_idx = wr_addr[IDX_W-1:0];
    assign rd_idx = rd_addr[IDX_W-1:0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && wr_hit && (wr_idx == IDX_W'(g))) begin
                regs_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= regs_d[g];
        end

        assign regs_flat[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    assign rd_data = rd_hit ? regs_q[rd_idx] : '0;
endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
    import spi_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic                cs_n,
    input  logic                pin_mode,
    input  logic                din,
    input  logic                reg0_lsb,
    input  logic                reg0_long,
    input  logic                reg0_4w,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic [WIDE_AW-1:0]  rd_addr,
    output logic                wr_en,
    output logic [WIDE_AW-1:0]  wr_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                out_bit,
    output logic                out_active,
    output logic                use_4w
);
    ctrl_state_t         d, q;
    logic [BYTE_W-1:0]   rx_n;
    logic [WIDE_AW-1:0]  next_addr;
    logic [WIDE_AW-1:0]  start;
    logic                rw_s;
    logic                idle;
    logic                abort;

    always_comb begin
        d         = q;
        wr_en     = 1'b0;
        rx_n      = q.cfg_lsb ? {din, q.rx[BYTE_W-1:1]} : {q.rx[BYTE_W-2:0], din};
        wr_addr   = q.addr;
        wr_data   = rx_n;
        rd_addr   = q.addr;
        next_addr = q.cfg_lsb ? q.addr + 1'b1 : q.addr - 1'b1;
        start     = q.addr;
        rw_s      = q.rw;
        idle      = (q.phase == PH_INSTR) && !q.hi_done && (q.bit_cnt == '0);
        abort     = pin_mode || (cs_n && (q.bit_cnt != '0));

        // control bits are copied only between transfers
        if (idle) begin
            d.cfg_lsb  = reg0_lsb;
            d.cfg_long = reg0_long;
            d.cfg_4w   = reg0_4w;
        end

        if (abort) begin
            d          = '0;
            d.cfg_lsb  = reg0_lsb;
            d.cfg_long = reg0_long;
            d.cfg_4w   = reg0_4w;
        end else if (rise && !cs_n) begin
            d.rx      = rx_n;
            d.bit_cnt = q.bit_cnt + 1'b1;
            if (q.reading) begin
                d.tx = q.cfg_lsb ? {1'b0, q.tx[BYTE_W-1:1]} : {q.tx[BYTE_W-2:0], 1'b0};
            end
            if (q.bit_cnt == 3'd7) begin
                if (q.phase == PH_INSTR) begin
                    if (q.cfg_long && !q.hi_done) begin
                        d.rw      = rx_n[7];
                        d.left    = rx_n[6:5];
                        d.addr    = {rx_n[4:0], 8'h00};
                        d.hi_done = 1'b1;
                    end else begin
                        if (q.cfg_long) begin
                            start = {q.addr[WIDE_AW-1:8], rx_n};
                            rw_s  = q.rw;
                        end else begin
                            start  = {8'h00, rx_n[4:0]};
                            rw_s   = rx_n[7];
                            d.left = rx_n[6:5];
                        end
                        d.rw      = rw_s;
                        d.addr    = start;
                        d.phase   = PH_DATA;
                        d.hi_done = 1'b0;
                        rd_addr   = start;
                        d.reading = rw_s;
                        d.tx      = rd_data;
                    end
                end else begin
                    wr_en = !q.rw;
                    if (q.left == 2'd0) begin
                        d          = '0;
                        d.cfg_lsb  = q.cfg_lsb;
                        d.cfg_long = q.cfg_long;
                        d.cfg_4w   = q.cfg_4w;
                    end else begin
                        d.left  = q.left - 1'b1;
                        d.addr  = next_addr;
                        rd_addr = next_addr;
                        d.tx    = rd_data;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_bit    = q.cfg_lsb ? q.tx[0] : q.tx[BYTE_W-1];
    assign out_active = q.reading;
    assign use_4w     = q.cfg_4w;
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int LSB_BIT   = 6,
    parameter int LONG_BIT  = 4,
    parameter int WIRE4_BIT = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pin_mode,
    input  logic                       sclk,
    input  logic                       cs_n,
    input  logic                       sdio_i,
    output logic                       sdio_o,
    output logic                       sdio_oe,
    output logic                       sdo,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    logic                rise;
    logic [WIDE_AW-1:0]  rd_addr, wr_addr;
    logic [BYTE_W-1:0]   rd_data, wr_data;
    logic                wr_en;
    logic                out_bit, out_active, use_4w;
    logic [BYTE_W-1:0]   reg0;
    logic                active;

    assign reg0 = regs_o[BYTE_W-1:0];

    spi_sclk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (rise)
    );

    spi_cfg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .cs_n       (cs_n),
        .pin_mode   (pin_mode),
        .din        (sdio_i),
        .reg0_lsb   (reg0[LSB_BIT]),
        .reg0_long  (reg0[LONG_BIT]),
        .reg0_4w    (reg0[WIRE4_BIT]),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .out_bit    (out_bit),
        .out_active (out_active),
        .use_4w     (use_4w)
    );

    spi_cfg_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

    assign active  = out_active && !cs_n && !pin_mode;
    assign sdio_oe = active && !use_4w;
    assign sdio_o  = sdio_oe && out_bit;
    assign sdo     = active && use_4w && out_bit;
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(
    parameter int NUM_REGS = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pin_mode,
    input logic                  cs_n,
    input logic                  sdio_oe,
    input logic                  sdo,
    input logic [NUM_REGS*8-1:0] regs_o
);
    // R4: no drive while deselected
    a_r4_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sdio_oe && !sdo));

    // R7: only one of the two pins carries read data
    a_r7_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> !sdo);

    // R11: pin mode silences both outputs
    a_r11_outputs_off: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode |-> (!sdio_oe && !sdo));

    // R11: pin mode freezes the register bank
    a_r11_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pin_mode) |-> $stable(regs_o));

    // R10: nothing is written while chip select is high
    a_r10_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> $stable(regs_o));
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_mode (pin_mode),
    .cs_n     (cs_n),
    .sdio_oe  (sdio_oe),
    .sdo      (sdo),
    .regs_o   (regs_o)
);

// File: tb/sim_spi_cfg_port.sv
module sim_spi_cfg_port;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pin_mode = 1'b0;
    logic         sclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         sdio_i = 1'b0;
    logic         sdio_o, sdio_oe, sdo;
    logic [255:0] regs_o;

    int nchecks = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [7:0] mem [32];
    logic [7:0] wbuf [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .sclk(sclk),
        .cs_n(cs_n), .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
        .sdo(sdo), .regs_o(regs_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] model_flat();
        logic [255:0] f;
        for (int i = 0; i < 32; i++) f[i*8 +: 8] = mem[i];
        return f;
    endfunction

    function automatic logic [7:0] model_rd(input logic [12:0] a);
        return (a < 13'd32) ? mem[a[4:0]] : 8'h00;
    endfunction

    function automatic logic [12:0] step(input logic [12:0] a, input bit lsb);
        return lsb ? a + 13'd1 : a - 13'd1;
    endfunction

    task automatic drive_bit(input logic v);
        @(negedge clk) sdio_i = v;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit lsb);
        for (int j = 0; j < 8; j++) drive_bit(lsb ? b[j] : b[7-j]);
    endtask

    task automatic stall_cs();
        @(negedge clk) cs_n = 1'b1;
        repeat (6) @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input bit rw, input int n, input logic [12:0] addr, input bit stall);
        bit lsb, lng, w4, pin_bad;
        logic [12:0] a;
        logic [7:0] got, exp;
        logic [1:0] nc;
        lsb = mem[0][6];
        lng = mem[0][4];
        w4  = mem[0][3];
        nc  = 2'(n - 1);
        @(negedge clk) cs_n = 1'b0;
        if (lng) begin
            send_byte({rw, nc, addr[12:8]}, lsb);
            if (stall) stall_cs();
            send_byte(addr[7:0], lsb);
            a = addr;
        end else begin
            send_byte({rw, nc, addr[4:0]}, lsb);
            a = {8'h00, addr[4:0]};
        end
        for (int k = 0; k < n; k++) begin
            if (stall) stall_cs();
            if (!rw) begin
                send_byte(wbuf[k], lsb);
                if (a < 13'd32) mem[a[4:0]] = wbuf[k];
                repeat (2) @(negedge clk);
                // R3 byte lands before the transfer ends; R2/R5/R6 address stepping
                chk(regs_o == model_flat(), "R3 write byte commit", regs_o, model_flat());
            end else begin
                pin_bad = 1'b0;
                got = '0;
                for (int j = 0; j < 8; j++) begin
                    logic v;
                    repeat (2) @(negedge clk);
                    v = w4 ? sdo : sdio_o;
                    if (w4 ? (sdio_oe !== 1'b0) : (sdio_oe !== 1'b1 || sdo !== 1'b0)) pin_bad = 1'b1;
                    if (lsb) got[j] = v; else got[7-j] = v;
                    sclk = 1'b1;
                    repeat (3) @(negedge clk);
                    sclk = 1'b0;
                end
                exp = model_rd(a);
                chk(got == exp, "R4 read byte", 256'(got), 256'(exp));
                chk(!pin_bad, "R7 read pin select", 256'(pin_bad), 256'(0));
            end
            a = step(a, lsb);
        end
        @(negedge clk) cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr1(input logic [12:0] addr, input logic [7:0] v);
        wbuf[0] = v;
        xfer(1'b0, 1, addr, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchecks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk(regs_o == '0, "R1 registers zero", regs_o, '0);
        chk(!sdio_oe && !sdo, "R1 outputs idle", 256'({sdio_oe, sdo}), 256'(0));

        // R2 four-byte write in MSB-first order, addresses 10,9,8,7
        wbuf[0] = 8'hA1; wbuf[1] = 8'h3C; wbuf[2] = 8'h80; wbuf[3] = 8'h01;
        xfer(1'b0, 4, 13'd10, 1'b0);
        xfer(1'b1, 4, 13'd10, 1'b0);
        // R2 decrement from 0 lands on an unimplemented address
        wbuf[0] = 8'h00; wbuf[1] = 8'hEE;
        xfer(1'b0, 2, 13'd0, 1'b0);

        // R10 partial byte aborts the transfer
        wr1(13'd7, 8'h5A);
        @(negedge clk) cs_n = 1'b0;
        send_byte(8'h07, 1'b0);
        for (int j = 0; j < 5; j++) drive_bit(1'b1);
        @(negedge clk) cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(regs_o == model_flat(), "R10 partial data byte dropped", regs_o, model_flat());
        @(negedge clk) cs_n = 1'b0;
        for (int j = 0; j < 3; j++) drive_bit(1'b1);
        @(negedge clk) cs_n = 1'b1;
        repeat (4) @(negedge clk);
        xfer(1'b1, 1, 13'd7, 1'b0);

        // R11 pin mode ignores the serial clock
        pin_mode = 1'b1;
        @(negedge clk) cs_n = 1'b0;
        send_byte(8'h07, 1'b0);
        send_byte(8'hFF, 1'b0);
        send_byte(8'h87, 1'b0);
        chk(!sdio_oe && !sdo, "R11 outputs off", 256'({sdio_oe, sdo}), 256'(0));
        chk(regs_o == model_flat(), "R11 registers untouched", regs_o, model_flat());
        @(negedge clk) cs_n = 1'b1;
        pin_mode = 1'b0;
        repeat (4) @(negedge clk);
        xfer(1'b1, 1, 13'd7, 1'b0);

        // R9 stalls between every byte
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        xfer(1'b0, 3, 13'd20, 1'b1);
        xfer(1'b1, 3, 13'd20, 1'b1);

        // R5 LSB-first order, address increments
        wr1(13'd0, 8'h40);
        wbuf[0] = 8'hC4; wbuf[1] = 8'h09;
        xfer(1'b0, 2, 13'd30, 1'b0);
        xfer(1'b1, 2, 13'd29, 1'b0);

        // R8 clearing the order bit mid-transfer affects only the next transfer
        wbuf[0] = 8'h00; wbuf[1] = 8'h01;
        xfer(1'b0, 2, 13'd0, 1'b0);
        chk(regs_o[15:8] == 8'h01, "R8 old order kept in transfer", 256'(regs_o[15:8]), 256'(8'h01));
        xfer(1'b1, 2, 13'd1, 1'b0);

        // R6 long instruction with unimplemented addresses
        wr1(13'd0, 8'h10);
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
        xfer(1'b0, 2, 13'h0021, 1'b0);
        chk(regs_o == model_flat(), "R6 unimplemented write ignored", regs_o, model_flat());
        wbuf[0] = 8'h5C; wbuf[1] = 8'h6D; wbuf[2] = 8'h7E;
        xfer(1'b0, 3, 13'h001F, 1'b1);
        xfer(1'b1, 2, 13'h0020, 1'b0);
        xfer(1'b1, 1, 13'h0100, 1'b0);

        // R7 four-wire read
        wr1(13'd0, 8'h08);
        xfer(1'b1, 3, 13'd10, 1'b0);

        // random transfers over every mode combination
        for (int m = 0; m < 8; m++) begin
            logic [7:0] c;
            c = {1'b0, m[0], 1'b0, m[1], m[2], 3'b000};
            wr1(13'd0, c);
            for (int r = 0; r < 20; r++) begin
                bit rw, st;
                int n;
                logic [12:0] a;
                rw = $urandom % 2;
                n  = 1 + ($urandom % 4);
                st = ($urandom % 4) == 0;
                if (mem[0][4]) begin
                    case ($urandom % 4)
                        0: a = 13'($urandom % 40);
                        1: a = 13'h1FFE + 13'($urandom % 2);
                        default: a = 13'($urandom % 32);
                    endcase
                end else begin
                    a = 13'($urandom % 32);
                end
                for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
                // keep the control register out of random writes
                if (!rw) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [12:0] t;
                        t = mem[0][6] ? a + 13'(k) : a - 13'(k);
                        if (k < n && t == 13'd0) wbuf[k] = mem[0];
                    end
                end
                xfer(rw, n, a, st);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end
endmodule